// File: doc/BRIEF.md
# Sinusoidal PWM Bridge Sequencer

This block drives the two gate-control channels of a single-phase full-bridge inverter with a table-driven sinusoidal PWM pattern. A prescaler turns the system clock into a base tick. Fifty ticks make one switching slot, and twenty slots make one half-wave. In each slot, the channel that owns the current half-wave goes high at the start of the slot. It stays high for the number of ticks held in a fixed, symmetric on-time table. The twentieth slot of every half-wave is a dead slot in which both channels stay low. The positive channel plays its half-wave first, then the negative channel plays the same pattern, and the sequence repeats.

With a 100 MHz clock and the default divider, the tick is 10 µs, a slot is 500 µs (2 kHz switching) and a full 40-slot cycle is 20 ms (50 Hz fundamental). An enable input gates both outputs and freezes the sequence position, so the block can be paused without losing phase. A half-wave flag shows which channel currently owns the sequence.

Top module: `spwm_bridge_seq`

## Requirements
- R1: While and just after a synchronous reset with enable low, both gate outputs and the half-wave flag are 0, and the sequence starts at tick 0 of slot 0 of the positive half-wave.
- R2: In slot s of a half-wave (s = 0..18), the owning channel is high for the first D(s) ticks of the slot and low for the rest. D in ticks is, for s = 0..18: 6, 9, 14, 18, 21, 25, 27, 29, 30, 30, 30, 29, 27, 25, 21, 18, 14, 9, 6, a pattern symmetric about s = 9.
- R3: The two gate outputs are never high in the same cycle. The positive output is high only while the flag is 0, and the negative output only while the flag is 1.
- R4: Slot 19 of each half-wave is dead: both outputs stay low for its 50 ticks.
- R5: While enable is low, both outputs are low and the tick, slot and half-wave position does not advance. When enable returns, the pattern resumes where it stopped.
- R6: The half-wave flag toggles after every 20 slots, so a full cycle is 40 slots (2000 ticks).
- R7: One tick lasts TICK_DIV enabled clock cycles, and one slot lasts TICKS_PER_SLOT (50) ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces the outputs off and freezes the position |
| gate_pos | output | 1 | Channel for the positive half-wave |
| gate_neg | output | 1 | Channel for the negative half-wave |
| half_neg | output | 1 | 0 while the positive channel owns the sequence, 1 while the negative channel owns it |

## Verification
The busiest cycle is the one where a tick ends a dead slot: the slot index wraps and the half-wave flag toggles in the same clock. At that moment, ownership must pass cleanly to the other channel, which must start its first pulse at once. Enable is switched at random, including in the cycles right around these wraps, so a pause can also land in the same cycle as a slot or half-wave change. A bench model counts enabled clocks, derives the expected tick, slot and half-wave from that count alone, and compares all three outputs in every cycle.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    localparam int SLOTS_PER_HALF = 20;
    localparam int DEAD_SLOT      = SLOTS_PER_HALF - 1;
    localparam int SLOT_W         = $clog2(SLOTS_PER_HALF);
    localparam int DUTY_W         = 8;

    typedef enum logic {
        HALF_POS = 1'b0,
        HALF_NEG = 1'b1
    } half_e;

    // On-time in ticks for a slot; rising half stored, falling half mirrored.
    function automatic logic [DUTY_W-1:0] duty_of(input logic [SLOT_W-1:0] slot);
        logic [SLOT_W-1:0] idx;
        logic [DUTY_W-1:0] val;
        idx = (slot > SLOT_W'(9)) ? SLOT_W'(18) - slot : slot;
        case (idx)
            SLOT_W'(0): val = 8'h06;
            SLOT_W'(1): val = 8'h09;
            SLOT_W'(2): val = 8'h0E;
            SLOT_W'(3): val = 8'h12;
            SLOT_W'(4): val = 8'h15;
            SLOT_W'(5): val = 8'h19;
            SLOT_W'(6): val = 8'h1B;
            SLOT_W'(7): val = 8'h1D;
            SLOT_W'(8): val = 8'h1E;
            SLOT_W'(9): val = 8'h1E;
            default:    val = 8'h00;
        endcase
        if (slot >= SLOT_W'(DEAD_SLOT)) val = 8'h00;
        return val;
    endfunction

endpackage

// File: rtl/spwm_tick_gen.sv
module spwm_tick_gen #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (en) begin
            if (cnt_q == CW'(TICK_DIV - 1)) begin
                cnt_d = '0;
                tick  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spwm_slot_seq.sv
module spwm_slot_seq
    import spwm_pkg::*;
#(
    parameter int TICKS_PER_SLOT = 50,
    parameter int TW = $clog2(TICKS_PER_SLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [TW-1:0]     tcnt,
    output logic [SLOT_W-1:0] slot,
    output half_e             half
);
    typedef struct packed {
        logic [TW-1:0]     tcnt;
        logic [SLOT_W-1:0] slot;
        half_e             half;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.tcnt == TW'(TICKS_PER_SLOT - 1)) begin
                st_d.tcnt = '0;
                if (st_q.slot == SLOT_W'(DEAD_SLOT)) begin
                    st_d.slot = '0;
                    st_d.half = (st_q.half == HALF_POS) ? HALF_NEG : HALF_POS;
                end else begin
                    st_d.slot = st_q.slot + 1'b1;
                end
            end else begin
                st_d.tcnt = st_q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{tcnt: '0, slot: '0, half: HALF_POS};
        else     st_q <= st_d;
    end

    assign tcnt = st_q.tcnt;
    assign slot = st_q.slot;
    assign half = st_q.half;
endmodule

// File: rtl/spwm_bridge_seq.sv
module spwm_bridge_seq
    import spwm_pkg::*;
#(
    parameter int TICK_DIV       = 1000,
    parameter int TICKS_PER_SLOT = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic gate_pos,
    output logic gate_neg,
    output logic half_neg
);
    localparam int TW = $clog2(TICKS_PER_SLOT);

    logic              tick_w;
    logic [TW-1:0]     tcnt_w;
    logic [SLOT_W-1:0] slot_w;
    half_e             half_w;
    logic [DUTY_W-1:0] duty_w;
    logic              on_w;

    spwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (tick_w)
    );

    spwm_slot_seq #(.TICKS_PER_SLOT(TICKS_PER_SLOT), .TW(TW)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_w),
        .tcnt (tcnt_w),
        .slot (slot_w),
        .half (half_w)
    );

    always_comb begin
        duty_w   = duty_of(slot_w);
        on_w     = en && (DUTY_W'(tcnt_w) < duty_w);
        gate_pos = on_w && (half_w == HALF_POS);
        gate_neg = on_w && (half_w == HALF_NEG);
        half_neg = (half_w == HALF_NEG);
    end
endmodule

// File: rtl/spwm_bridge_chk.sv
module spwm_bridge_chk #(
    parameter int TICKS_PER_SLOT = 50,
    parameter int TW = 6,
    parameter int SW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          gate_pos,
    input logic          gate_neg,
    input logic          half_neg,
    input logic [TW-1:0] tcnt,
    input logic [SW-1:0] slot
);
    // R3: channels exclusive and tied to the owning half-wave
    p_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(gate_pos && gate_neg));
    p_owner_r3: assert property (@(posedge clk) disable iff (rst)
        (gate_pos |-> !half_neg) and (gate_neg |-> half_neg));
    // R4: dead slot keeps both channels off
    p_dead_r4: assert property (@(posedge clk) disable iff (rst)
        (slot == SW'(19)) |-> (!gate_pos && !gate_neg));
    // R5: disabled means off and frozen
    p_off_r5: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!gate_pos && !gate_neg));
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(tcnt) && $stable(slot) && $stable(half_neg)));
    // R6: flag flips only as the last tick of the dead slot ends
    p_flip_r6: assert property (@(posedge clk) disable iff (rst)
        (half_neg != $past(half_neg)) |->
        ($past(slot) == SW'(19) && $past(tcnt) == TW'(TICKS_PER_SLOT - 1)));
    // R2: no pulse reaches beyond the widest table entry
    p_width_r2: assert property (@(posedge clk) disable iff (rst)
        (gate_pos || gate_neg) |-> (tcnt < TW'(30)));
endmodule

bind spwm_bridge_seq spwm_bridge_chk #(
    .TICKS_PER_SLOT(TICKS_PER_SLOT), .TW(TW), .SW(spwm_pkg::SLOT_W)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .gate_pos(gate_pos), .gate_neg(gate_neg),
    .half_neg(half_neg), .tcnt(tcnt_w), .slot(slot_w)
);

// File: tb/sim_spwm_bridge_seq.sv
`timescale 1ns/1ps
module sim_spwm_bridge_seq;
    localparam int DIV = 2;
    localparam int TPS = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic gate_pos, gate_neg, half_neg;

    int checks = 0;
    int errors = 0;
    int p = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spwm_bridge_seq #(.TICK_DIV(DIV), .TICKS_PER_SLOT(TPS)) u0 (
        .clk(clk), .rst(rst), .en(en),
        .gate_pos(gate_pos), .gate_neg(gate_neg), .half_neg(half_neg)
    );

    function automatic int tbl(input int s);
        case (s)
            0: return 6;   1: return 9;   2: return 14;  3: return 18;
            4: return 21;  5: return 25;  6: return 27;  7: return 29;
            8: return 30;  9: return 30;  10: return 30; 11: return 29;
            12: return 27; 13: return 25; 14: return 21; 15: return 18;
            16: return 14; 17: return 9;  18: return 6;  default: return 0;
        endcase
    endfunction

    task automatic cmp(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at p=%0d", req, what, act, exp, p);
        end
    endtask

    task automatic check_now();
        int k, tc, sl, hf;
        logic ep, en_, eh;
        string tag;
        k  = p / DIV;
        tc = k % TPS;
        sl = (k / TPS) % 20;
        hf = (k / (TPS * 20)) % 2;
        ep = en && (hf == 0) && (tc < tbl(sl));
        en_ = en && (hf == 1) && (tc < tbl(sl));
        eh = (hf == 1);
        if (!en)                            tag = "R5";
        else if (sl == 19)                  tag = "R4";
        else if (tc == 0 && (p % DIV) == 0) tag = "R7";
        else                                tag = "R2";
        cmp(tag, "gate_pos", gate_pos, ep);
        cmp((tag == "R2") ? "R3" : tag, "gate_neg", gate_neg, en_);
        cmp("R6", "half_neg", half_neg, eh);
    endtask

    task automatic cycle(input logic en_v);
        @(negedge clk);
        en = en_v;
        #1;
        if (!rst) check_now();
        @(posedge clk);
        if (rst) p = 0;
        else if (en) p++;
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        cmp("R1", "gate_pos", gate_pos, 1'b0);
        cmp("R1", "gate_neg", gate_neg, 1'b0);
        cmp("R1", "half_neg", half_neg, 1'b0);
        rst = 1'b0;
        p = 0;
        // R1: first enabled cycle is slot 0 of the positive channel
        cycle(1'b1);
        // R2/R4/R6/R7: two full cycles uninterrupted
        for (int i = 0; i < 2 * 40 * TPS * DIV + 50; i++) cycle(1'b1);
        // R5: random pauses, including around slot and half-wave wraps
        for (int i = 0; i < 10000; i++) cycle(($urandom % 10) < 7);
        // R5: long pause then resume
        for (int i = 0; i < 300; i++) cycle(1'b0);
        for (int i = 0; i < 2000; i++) cycle(1'b1);
        // R1: reset mid-run with enable high
        @(negedge clk); rst = 1'b1;
        @(posedge clk); p = 0;
        @(negedge clk); rst = 1'b0; en = 1'b0; #1;
        cmp("R1", "gate_pos", gate_pos, 1'b0);
        cmp("R1", "half_neg", half_neg, 1'b0);
        @(posedge clk);
        for (int i = 0; i < 4200; i++) cycle(($urandom % 8) != 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule